// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block sits between a requester and a byte-addressed target memory and turns a 32 MB alias window into single-bit access to a 1 MB target region. Every 32-bit alias word stands for exactly one bit of the target. A read of an alias word fetches the target unit that contains the bit and returns that bit alone. A write to an alias word reads the target unit, changes only the selected bit, and writes the unit back. The requester sees all of this as one access.

The requester side takes an address, an access size, a write flag, write data and an attribute field, and is held off with a ready signal while the bridge is busy. The target side issues one read and, for writes, one write-back. Each is held until the target acknowledges it, and the target's error flag comes back with the acknowledge. A chip places two copies: one with alias base 0x22000000 over target base 0x20000000, and one with alias base 0x42000000 over target base 0x40000000. Each copy is selected by its parameters.

Top module: `bitband_bridge`

## Requirements
- R1: For alias offset `off = s_addr[24:0]`, the target address before rounding is `TARGET_BASE | (off >> 5)`. Every target access lies inside the 1 MB region that starts at `TARGET_BASE`.
- R2: `s_size` encodes the unit as 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes (3 is handled as 4 bytes). The target address is rounded down to a multiple of the unit, and `m_size` carries the same code.
- R3: The selected bit index is `off[6:2] AND (unit_bits - 1)`. The unit travels right-justified and little-endian on `m_rdata`/`m_wdata`, with byte 0 of the unit in bits 7:0, so the index picks bit `index` of that bus.
- R4: A read returns the selected bit in `s_rdata[0]` with bits 31:1 zero. It issues exactly one target read and no target write.
- R5: A write issues one target read and then one target write of the whole unit. In that write, the selected bit equals `s_wdata[0]`, every other bit of the unit equals what was read, and `s_wdata[31:1]` has no effect.
- R6: If the target read returns `m_err = 1`, the response carries `s_err = 1` and `s_rdata = 0`, and no target write is issued. An error on the write-back is also reported in `s_err`.
- R7: `m_attr` equals the accepted `s_attr` on both the read and the write-back, and it stays stable while a target access is pending.
- R8: After reset `s_ready = 1`, `m_req = 0` and `s_done = 0`. A request is accepted when `s_valid && s_ready`, and `s_ready` stays low until the single `s_done` pulse that answers it. `m_req`, `m_addr` and `m_write` are held until `m_ack`.
- R9: The bridge works with either placement: the SRAM alias at 0x22000000 over 0x20000000, and the peripheral alias at 0x42000000 over 0x40000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Request present |
| s_ready | output | 1 | Bridge idle, can accept a request |
| s_addr | input | 32 | Alias address |
| s_size | input | 2 | Unit size code (0 = 1 B, 1 = 2 B, 2 = 4 B) |
| s_write | input | 1 | 1 = write, 0 = read |
| s_wdata | input | 32 | Write data; only bit 0 is used |
| s_attr | input | 2 | Access attributes passed to the target |
| s_done | output | 1 | One-cycle response pulse |
| s_rdata | output | 32 | Read result (selected bit in bit 0) |
| s_err | output | 1 | Response error |
| m_req | output | 1 | Target access pending |
| m_write | output | 1 | Target access is the write-back |
| m_addr | output | 32 | Target byte address, unit-aligned |
| m_size | output | 2 | Target unit size code |
| m_wdata | output | 32 | Write-back unit, right-justified |
| m_attr | output | 2 | Attributes of the target access |
| m_ack | input | 1 | Target access complete |
| m_rdata | input | 32 | Fetched unit, right-justified |
| m_err | input | 1 | Target error, valid with m_ack |

## Verification
The bench builds two bridges side by side. One keeps the default SRAM parameters (alias 0x22000000, target 0x20000000) and the other is built with the peripheral parameters (alias 0x42000000, target 0x40000000), so both placements are exercised against separate target models. Each target model answers with a one-cycle acknowledge, pads the unused upper bytes of a fetch with filler, and returns an error for any target byte offset with bit 9 set. These choices put the aligned-address checks, the masking of the bit index per size, and the error path with its suppressed write-back within reach of ordinary stimulus.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam int BB_AW     = 32;
    localparam int BB_DW     = 32;
    localparam int BB_ATTR_W = 2;
    localparam int BB_WIN_W  = 25;               // 32 MB alias window
    localparam int BB_BIT_W  = $clog2(BB_DW);    // bit index width
    localparam int BB_SHIFT  = 5;                // alias bytes per target byte, log2

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_RSP  = 2'd3
    } bb_state_e;

    typedef struct packed {
        logic [BB_AW-1:0]     taddr;
        logic [1:0]           size;
        logic [BB_BIT_W-1:0]  bitpos;
        logic                 write;
        logic                 wbit;
        logic [BB_ATTR_W-1:0] attr;
    } bb_req_t;

    // byte-offset mask of a unit
    function automatic logic [1:0] bb_lane_mask(input logic [1:0] size);
        case (size)
            2'd0:    return 2'b00;
            2'd1:    return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    // bit-index mask of a unit
    function automatic logic [BB_BIT_W-1:0] bb_bit_mask(input logic [1:0] size);
        case (size)
            2'd0:    return BB_BIT_W'(7);
            2'd1:    return BB_BIT_W'(15);
            default: return BB_BIT_W'(31);
        endcase
    endfunction
endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
    import bb_pkg::*;
#(
    parameter logic [BB_AW-1:0] TARGET_BASE = 32'h2000_0000
) (
    input  logic [BB_AW-1:0]    alias_addr,
    input  logic [1:0]          size,
    output logic [BB_AW-1:0]    tgt_addr,
    output logic [BB_BIT_W-1:0] bitpos
);
    logic [BB_WIN_W-1:0] off;
    logic [BB_AW-1:0]    spread;

    always_comb begin
        off      = alias_addr[BB_WIN_W-1:0];
        spread   = TARGET_BASE | BB_AW'(off >> BB_SHIFT);
        tgt_addr = spread & ~BB_AW'(bb_lane_mask(size));
        bitpos   = off[BB_BIT_W+1:2] & bb_bit_mask(size);
    end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
    import bb_pkg::*;
(
    input  logic [BB_DW-1:0]    unit_in,
    input  logic [BB_BIT_W-1:0] bitpos,
    input  logic                new_bit,
    output logic [BB_DW-1:0]    unit_out,
    output logic                sel_bit
);
    for (genvar i = 0; i < BB_DW; i++) begin : g_bit
        assign unit_out[i] = (bitpos == BB_BIT_W'(i)) ? new_bit : unit_in[i];
    end

    assign sel_bit = unit_in[bitpos];
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
    import bb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 s_valid,
    input  bb_req_t              req_in,
    output logic                 s_ready,
    output logic                 s_done,
    output logic [BB_DW-1:0]     s_rdata,
    output logic                 s_err,
    output logic                 m_req,
    output logic                 m_write,
    output logic [BB_AW-1:0]     m_addr,
    output logic [1:0]           m_size,
    output logic [BB_DW-1:0]     m_wdata,
    output logic [BB_ATTR_W-1:0] m_attr,
    input  logic                 m_ack,
    input  logic [BB_DW-1:0]     m_rdata,
    input  logic                 m_err
);
    bb_state_e        st;
    bb_req_t          req_q;
    logic [BB_DW-1:0] rd_q;
    logic [BB_DW-1:0] rdata_q;
    logic             err_q;
    logic [BB_DW-1:0] merge_src;
    logic [BB_DW-1:0] merged;
    logic             sel_bit;

    assign merge_src = (st == ST_RD) ? m_rdata : rd_q;

    bb_bit_merge u_merge (
        .unit_in  (merge_src),
        .bitpos   (req_q.bitpos),
        .new_bit  (req_q.wbit),
        .unit_out (merged),
        .sel_bit  (sel_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            req_q   <= '0;
            rd_q    <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (s_valid) begin
                        req_q <= req_in;
                        st    <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (m_ack) begin
                        rd_q <= m_rdata;
                        if (m_err) begin
                            err_q   <= 1'b1;
                            rdata_q <= '0;
                            st      <= ST_RSP;
                        end else if (req_q.write) begin
                            err_q   <= 1'b0;
                            rdata_q <= '0;
                            st      <= ST_WR;
                        end else begin
                            err_q   <= 1'b0;
                            rdata_q <= BB_DW'(sel_bit);
                            st      <= ST_RSP;
                        end
                    end
                end
                ST_WR: begin
                    if (m_ack) begin
                        err_q <= m_err;
                        st    <= ST_RSP;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign s_ready = (st == ST_IDLE);
    assign s_done  = (st == ST_RSP);
    assign s_rdata = rdata_q;
    assign s_err   = err_q;
    assign m_req   = (st == ST_RD) || (st == ST_WR);
    assign m_write = (st == ST_WR);
    assign m_addr  = req_q.taddr;
    assign m_size  = req_q.size;
    assign m_wdata = merged;
    assign m_attr  = req_q.attr;

    AST_UNIT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        m_req |-> ((m_addr[1:0] & bb_lane_mask(m_size)) == 2'b00)); // R2
    AST_RDATA_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        s_done |-> (s_rdata[BB_DW-1:1] == '0)); // R4
    AST_WB_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_write) |-> ($countones(m_wdata ^ rd_q) <= 1)); // R5
    AST_NO_WB_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_write && m_ack && m_err) |=> !m_req); // R6
    AST_ATTR_HELD: assert property (@(posedge clk) disable iff (rst)
        (m_req && $past(m_req)) |-> $stable(m_attr)); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (m_req || s_done) |-> !s_ready); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_write))); // R8
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter logic [BB_AW-1:0] ALIAS_BASE  = 32'h2200_0000,
    parameter logic [BB_AW-1:0] TARGET_BASE = 32'h2000_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 s_valid,
    output logic                 s_ready,
    input  logic [BB_AW-1:0]     s_addr,
    input  logic [1:0]           s_size,
    input  logic                 s_write,
    input  logic [BB_DW-1:0]     s_wdata,
    input  logic [BB_ATTR_W-1:0] s_attr,
    output logic                 s_done,
    output logic [BB_DW-1:0]     s_rdata,
    output logic                 s_err,
    output logic                 m_req,
    output logic                 m_write,
    output logic [BB_AW-1:0]     m_addr,
    output logic [1:0]           m_size,
    output logic [BB_DW-1:0]     m_wdata,
    output logic [BB_ATTR_W-1:0] m_attr,
    input  logic                 m_ack,
    input  logic [BB_DW-1:0]     m_rdata,
    input  logic                 m_err
);
    localparam int TGT_SPAN_W = BB_WIN_W - BB_SHIFT;   // 1 MB target region

    logic [BB_AW-1:0]    tgt_addr;
    logic [BB_BIT_W-1:0] bitpos;
    bb_req_t             req_in;

    bb_addr_map #(.TARGET_BASE(TARGET_BASE)) u_map (
        .alias_addr (s_addr),
        .size       (s_size),
        .tgt_addr   (tgt_addr),
        .bitpos     (bitpos)
    );

    always_comb begin
        req_in.taddr  = tgt_addr;
        req_in.size   = s_size;
        req_in.bitpos = bitpos;
        req_in.write  = s_write;
        req_in.wbit   = s_wdata[0];
        req_in.attr   = s_attr;
    end

    bb_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .s_valid (s_valid),
        .req_in  (req_in),
        .s_ready (s_ready),
        .s_done  (s_done),
        .s_rdata (s_rdata),
        .s_err   (s_err),
        .m_req   (m_req),
        .m_write (m_write),
        .m_addr  (m_addr),
        .m_size  (m_size),
        .m_wdata (m_wdata),
        .m_attr  (m_attr),
        .m_ack   (m_ack),
        .m_rdata (m_rdata),
        .m_err   (m_err)
    );

    AST_ALIAS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |-> (s_addr[BB_AW-1:BB_WIN_W] == ALIAS_BASE[BB_AW-1:BB_WIN_W])); // R1
    AST_TGT_REGION: assert property (@(posedge clk) disable iff (rst)
        m_req |-> (m_addr[BB_AW-1:TGT_SPAN_W] == TARGET_BASE[BB_AW-1:TGT_SPAN_W])); // R1
endmodule

// File: tb/bitband_bridge_bench.sv
module bb_tgt_mem (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic        write,
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    input  logic [1:0]  attr,
    output logic        ack,
    output logic [31:0] rdata,
    output logic        err,
    output int          wr_cnt,
    output logic [31:0] last_addr,
    output logic [31:0] last_wdata,
    output logic [1:0]  last_attr,
    output logic [1:0]  last_size
);
    logic [7:0] mem [512];

    function automatic int lanes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0; err <= 1'b0; wr_cnt <= 0; rdata <= '0;
            last_addr <= '0; last_wdata <= '0; last_attr <= '0; last_size <= '0;
            for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 37 + 11);
        end else if (ack) begin
            ack <= 1'b0;
        end else if (req) begin
            ack       <= 1'b1;
            err       <= addr[9];
            last_addr <= addr;
            last_attr <= attr;
            last_size <= size;
            for (int k = 0; k < 4; k++)
                rdata[8*k +: 8] <= (k < lanes(size)) ? mem[9'(addr[8:0] + 9'(k))] : 8'hEE;
            if (write && !addr[9]) begin
                wr_cnt     <= wr_cnt + 1;
                last_wdata <= wdata;
                for (int k = 0; k < 4; k++)
                    if (k < lanes(size)) mem[9'(addr[8:0] + 9'(k))] <= wdata[8*k +: 8];
            end
        end
    end
endmodule

module bitband_bridge_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;   // 200 MHz

    logic        s_valid [2];
    logic        s_ready [2];
    logic [31:0] s_addr  [2];
    logic [1:0]  s_size  [2];
    logic        s_write [2];
    logic [31:0] s_wdata [2];
    logic [1:0]  s_attr  [2];
    logic        s_done  [2];
    logic [31:0] s_rdata [2];
    logic        s_err   [2];
    logic        m_req   [2];
    logic        m_write [2];
    logic [31:0] m_addr  [2];
    logic [1:0]  m_size  [2];
    logic [31:0] m_wdata [2];
    logic [1:0]  m_attr  [2];
    logic        m_ack   [2];
    logic [31:0] m_rdata [2];
    logic        m_err   [2];
    int          wr_cnt  [2];
    logic [31:0] l_addr  [2];
    logic [31:0] l_wdata [2];
    logic [1:0]  l_attr  [2];
    logic [1:0]  l_size  [2];

    localparam logic [31:0] ABASE [2] = '{32'h2200_0000, 32'h4200_0000};
    localparam logic [31:0] TBASE [2] = '{32'h2000_0000, 32'h4000_0000};

    bitband_bridge u_bitband_bridge (
        .clk(clk), .rst(rst), .s_valid(s_valid[0]), .s_ready(s_ready[0]),
        .s_addr(s_addr[0]), .s_size(s_size[0]), .s_write(s_write[0]),
        .s_wdata(s_wdata[0]), .s_attr(s_attr[0]), .s_done(s_done[0]),
        .s_rdata(s_rdata[0]), .s_err(s_err[0]), .m_req(m_req[0]),
        .m_write(m_write[0]), .m_addr(m_addr[0]), .m_size(m_size[0]),
        .m_wdata(m_wdata[0]), .m_attr(m_attr[0]), .m_ack(m_ack[0]),
        .m_rdata(m_rdata[0]), .m_err(m_err[0]));

    bitband_bridge #(.ALIAS_BASE(32'h4200_0000), .TARGET_BASE(32'h4000_0000))
    u_bitband_bridge_periph (
        .clk(clk), .rst(rst), .s_valid(s_valid[1]), .s_ready(s_ready[1]),
        .s_addr(s_addr[1]), .s_size(s_size[1]), .s_write(s_write[1]),
        .s_wdata(s_wdata[1]), .s_attr(s_attr[1]), .s_done(s_done[1]),
        .s_rdata(s_rdata[1]), .s_err(s_err[1]), .m_req(m_req[1]),
        .m_write(m_write[1]), .m_addr(m_addr[1]), .m_size(m_size[1]),
        .m_wdata(m_wdata[1]), .m_attr(m_attr[1]), .m_ack(m_ack[1]),
        .m_rdata(m_rdata[1]), .m_err(m_err[1]));

    bb_tgt_mem u_mem_sram (
        .clk(clk), .rst(rst), .req(m_req[0]), .write(m_write[0]), .addr(m_addr[0]),
        .size(m_size[0]), .wdata(m_wdata[0]), .attr(m_attr[0]), .ack(m_ack[0]),
        .rdata(m_rdata[0]), .err(m_err[0]), .wr_cnt(wr_cnt[0]), .last_addr(l_addr[0]),
        .last_wdata(l_wdata[0]), .last_attr(l_attr[0]), .last_size(l_size[0]));

    bb_tgt_mem u_mem_periph (
        .clk(clk), .rst(rst), .req(m_req[1]), .write(m_write[1]), .addr(m_addr[1]),
        .size(m_size[1]), .wdata(m_wdata[1]), .attr(m_attr[1]), .ack(m_ack[1]),
        .rdata(m_rdata[1]), .err(m_err[1]), .wr_cnt(wr_cnt[1]), .last_addr(l_addr[1]),
        .last_wdata(l_wdata[1]), .last_attr(l_attr[1]), .last_size(l_size[1]));

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic [7:0] shadow [2][512];

    int          q_inst [$];
    logic [31:0] q_rd   [$];
    logic        q_err  [$];
    string       q_tag  [$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each response
    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < 2; k++) begin
                if (s_done[k]) begin
                    if (q_inst.size() == 0) begin
                        chk(1'b0, "R8", 32'(k), 32'hFFFF_FFFF, "response with nothing pending");
                    end else begin
                        int          ei;
                        logic [31:0] er;
                        logic        ee;
                        string       et;
                        ei = q_inst.pop_front();
                        er = q_rd.pop_front();
                        ee = q_err.pop_front();
                        et = q_tag.pop_front();
                        chk(ei == k, "R8", 32'(k), 32'(ei), "responding instance");
                        chk(s_rdata[k] == er, et, s_rdata[k], er, "response data");
                        chk(s_err[k] == ee, et, 32'(s_err[k]), 32'(ee), "response error");
                    end
                end
            end
        end
    end

    // driver: computes expectations from the requirements, then drives
    task automatic issue(input int inst, input logic [24:0] off, input logic [1:0] size,
                         input logic wr, input logic [31:0] wd, input logic [1:0] attr);
        int          ub;
        logic [31:0] tb;
        int          bp;
        int          idx;
        logic        eerr;
        logic [31:0] erd;
        logic [31:0] eunit;
        int          wr0;
        string       tag;
        ub   = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;         // R2
        tb   = 32'(off) >> 5;                                       // R1
        tb   = tb & ~32'(ub - 1);
        bp   = int'((off >> 2) & 25'(ub * 8 - 1));                  // R3
        idx  = int'(tb[8:0]) + bp / 8;
        eerr = tb[9];
        erd  = '0;
        if (!eerr && !wr) erd = 32'(shadow[inst][idx % 512][bp % 8]);
        if (!eerr && wr) shadow[inst][idx % 512][bp % 8] = wd[0];
        eunit = '0;
        for (int k = 0; k < ub; k++) eunit[8*k +: 8] = shadow[inst][(int'(tb[8:0]) + k) % 512];
        tag = eerr ? "R6" : (wr ? "R5" : "R4");
        q_inst.push_back(inst); q_rd.push_back(erd); q_err.push_back(eerr); q_tag.push_back(tag);

        @(negedge clk);
        while (!s_ready[inst]) @(negedge clk);
        wr0 = wr_cnt[inst];
        s_valid[inst] = 1'b1;
        s_addr[inst]  = ABASE[inst] | 32'(off);
        s_size[inst]  = size;
        s_write[inst] = wr;
        s_wdata[inst] = wd;
        s_attr[inst]  = attr;
        @(negedge clk);
        s_valid[inst] = 1'b0;
        chk(s_ready[inst] == 1'b0, "R8", 32'(s_ready[inst]), 32'd0, "ready while busy");
        while (!s_done[inst]) @(negedge clk);
        @(negedge clk);
        chk(l_addr[inst] == (TBASE[inst] | tb), (inst == 1) ? "R9" : "R1",
            l_addr[inst], TBASE[inst] | tb, "target address");
        chk(l_size[inst] == size, "R2", 32'(l_size[inst]), 32'(size), "target size");
        chk(l_attr[inst] == attr, "R7", 32'(l_attr[inst]), 32'(attr), "target attributes");
        chk(wr_cnt[inst] - wr0 == ((wr && !eerr) ? 1 : 0), tag,
            32'(wr_cnt[inst] - wr0), (wr && !eerr) ? 32'd1 : 32'd0, "target write count");
        if (wr && !eerr) begin
            logic [31:0] um;
            um = (ub == 4) ? 32'hFFFF_FFFF : ((32'd1 << (ub * 8)) - 32'd1);
            chk((l_wdata[inst] & um) == eunit, "R5", l_wdata[inst] & um, eunit, "written unit");
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            chk(1'b0, "R8", 32'(cyc), 32'd50000, "watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        for (int k = 0; k < 2; k++) begin
            s_valid[k] = 1'b0; s_addr[k] = ABASE[k]; s_size[k] = 2'd2;
            s_write[k] = 1'b0; s_wdata[k] = '0; s_attr[k] = '0;
            for (int i = 0; i < 512; i++) shadow[k][i] = 8'(i * 37 + 11);
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(s_ready[k] == 1'b1, "R8", 32'(s_ready[k]), 32'd1, "reset ready");
            chk(m_req[k] == 1'b0, "R8", 32'(m_req[k]), 32'd0, "reset target request");
            chk(s_done[k] == 1'b0, "R8", 32'(s_done[k]), 32'd0, "reset done");
        end

        // R4 word read of bit 3 of byte 0x10, then R5 set/clear and read back
        issue(0, 25'h0020C, 2'd2, 1'b0, 32'h0, 2'd1);
        issue(0, 25'h0020C, 2'd2, 1'b1, 32'h1, 2'd2);
        issue(0, 25'h0020C, 2'd2, 1'b0, 32'h0, 2'd3);
        issue(0, 25'h0020C, 2'd2, 1'b1, 32'hFFFF_FFFE, 2'd0);  // R5 upper data bits ignored
        issue(0, 25'h0020C, 2'd2, 1'b0, 32'h0, 2'd1);
        // R3 top bit of a word unit, and index masking for byte and half units
        issue(1, 25'h0047C, 2'd2, 1'b1, 32'h1, 2'd3);
        issue(1, 25'h0047C, 2'd0, 1'b0, 32'h0, 2'd2);
        issue(1, 25'h0047C, 2'd1, 1'b0, 32'h0, 2'd1);
        issue(1, 25'h0047C, 2'd2, 1'b0, 32'h0, 2'd0);
        // R6 error on target read: no write-back, error returned
        issue(0, 25'h04000, 2'd2, 1'b1, 32'h1, 2'd2);
        issue(1, 25'h04124, 2'd0, 1'b0, 32'h0, 2'd1);
        issue(1, 25'h04124, 2'd1, 1'b1, 32'h0, 2'd3);

        // mixed stimulus across both placements (R9)
        lcg = 32'h1234_5678;
        for (int i = 0; i < 80; i++) begin
            logic [24:0] off;
            logic [1:0]  sz;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            off = 25'(lcg[27:14]);
            sz  = (lcg[5:4] == 2'd3) ? 2'd2 : lcg[5:4];
            issue(i % 2, off, sz, lcg[2], {lcg[31:1], lcg[8]}, lcg[11:10]);
        end

        repeat (4) @(negedge clk);
        chk(q_inst.size() == 0, "R8", 32'(q_inst.size()), 32'd0, "responses outstanding");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule